// File: doc/BRIEF.md
# Paged Slot and Memory Map Decoder

This block sits between a CPU with a 24-bit address bus and the memory devices behind it. The top byte of the address picks one of five regions: a legacy 64 KB window, linear DRAM, two extended slot connectors, or an internal flash slot. The extended slot connectors each get their own select line, so an add-in card needs no address decoder of its own.

The legacy 64 KB window is split into four 16 KB pages. A slot-select register, written as an I/O port, assigns one of four slots to each page. Slot 3 reaches DRAM through four mapper page registers. Slots 0 to 2 reach a fixed layout of ROM images in a 128 KB boot flash. One of those images is a 64 KB DOS ROM, which appears in page 1 as four banks chosen by a memory-mapped bank register.

The lowest four bytes of the CPU space always go to a trap ROM that holds the invalid-opcode exception vector. A read from a page whose slot has no device returns FFh. All selects are combinational from the address and the registers. Register writes take effect from the clock edge on which the write strobe is sampled.

Top module: `slot_map_decoder`

## Requirements
- R1: When a memory cycle is active, address bits [23:16] in 01h..3Fh assert `dram_cs` with `dram_addr` = addr[21:0]; 40h..7Fh assert `ext_cs` = 01b; 80h..BFh assert `ext_cs` = 10b; C0h..FFh assert `flash_cs` with `flash_addr` = addr[21:0].
- R2: A memory cycle to 000000h..000003h asserts only `trap_cs`, whatever the slot register holds, and `slot_cs` stays 0.
- R3: The slot register sits at I/O port A8h and resets to 00h. Bits [2p+1:2p] give the slot of page p, where p = addr[15:14]. A memory cycle in the 00h region outside the trap bytes drives `slot_cs` one-hot with bit n meaning slot n.
- R4: Slot 3 selects DRAM with `dram_addr` = {mapper[p], addr[13:0]}. The mapper registers for pages 0..3 are at I/O ports FCh..FFh and reset to 3, 2, 1, 0.
- R5: The boot ROM layout, as `rom_addr` = {block, addr[13:0]}, is: slot 0 page 0 is block 0; slot 0 page 1 is block 1; slot 1 page 0 is block 2; slot 1 page 1 is block 3; slot 2 page 1 is block 4 + DOS bank.
- R6: A memory write to 004104h while page 1 is mapped to slot 2 loads the DOS bank from wdata[1:0]. The bank resets to 0, and the same write with page 1 on any other slot is ignored.
- R7: A slot/page pair with no device asserts no chip select. A memory read from it drives `rd_drive` high with `rd_data` = FFh.
- R8: An I/O read of port A8h or FCh..FFh drives `rd_drive` high and returns the addressed register on `rd_data`.
- R9: At most one of `trap_cs`, `rom_cs`, `dram_cs`, `flash_cs` and the two `ext_cs` bits is high at any time.
- R10: With neither `mem_rd` nor `mem_wr` high, every chip select and `slot_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 24 | CPU address; the I/O port is addr[7:0] |
| wdata | input | 8 | CPU write data |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| trap_cs | output | 1 | Trap ROM select |
| rom_cs | output | 1 | Boot flash select |
| rom_addr | output | 17 | Boot flash byte address |
| dram_cs | output | 1 | DRAM select |
| dram_addr | output | 22 | DRAM byte address |
| flash_cs | output | 1 | Internal flash slot select |
| flash_addr | output | 22 | Internal flash byte address |
| ext_cs | output | 2 | Extended slot connector selects |
| slot_cs | output | 4 | One-hot slot selected in the legacy window |
| page | output | 2 | Current 16 KB page number |
| rd_drive | output | 1 | Decoder drives the read data bus |
| rd_data | output | 8 | Register readback or FFh filler |

## Verification
A wrong slot register value shows up on the next memory access to the affected page: `slot_cs` changes, and with it the choice between ROM block, DRAM and the FFh filler. A corrupted mapper entry changes only the upper eight bits of `dram_addr`, and only when that page runs on slot 3. For that reason, each mapper entry is read back through its I/O port and also exercised by a slot 3 access. A lost DOS bank write is invisible until page 1 is next switched to slot 2. The bench therefore toggles page 1 away from slot 2, writes the bank register, switches back, and confirms the bank did not move.

// File: rtl/slot_map_decoder.sv
module slot_map_decoder #(
  parameter logic [7:0]  SLOT_PORT = 8'hA8,
  parameter logic [7:0]  MAP_PORT  = 8'hFC,
  parameter logic [15:0] BANK_ADDR = 16'h4104
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] addr,
  input  logic [7:0]  wdata,
  input  logic        mem_rd,
  input  logic        mem_wr,
  input  logic        io_rd,
  input  logic        io_wr,
  output logic        trap_cs,
  output logic        rom_cs,
  output logic [16:0] rom_addr,
  output logic        dram_cs,
  output logic [21:0] dram_addr,
  output logic        flash_cs,
  output logic [21:0] flash_addr,
  output logic [1:0]  ext_cs,
  output logic [3:0]  slot_cs,
  output logic [1:0]  page,
  output logic        rd_drive,
  output logic [7:0]  rd_data
);

  logic [7:0] slot_q;
  logic [7:0] map_q [4];
  logic [1:0] bank_q;

  logic       mem_cyc, legacy, trap, win_hit, rom_hit, unmapped;
  logic [1:0] slot, region;
  logic [2:0] blk;
  logic [7:0] port;
  logic       slot_port, map_port;

  assign mem_cyc = mem_rd | mem_wr;
  assign legacy  = addr[23:16] == 8'h00;
  assign trap    = legacy && addr[15:2] == 14'd0;
  assign region  = addr[23:22];
  assign page    = addr[15:14];
  assign slot    = 2'(slot_q >> {page, 1'b0});
  assign win_hit = mem_cyc && legacy && !trap;
  assign port    = addr[7:0];
  assign slot_port = port == SLOT_PORT;
  assign map_port  = port[7:2] == MAP_PORT[7:2];

  always_comb begin
    rom_hit = 1'b1;
    blk     = 3'd0;
    case ({slot, page})
      4'b00_00: blk = 3'd0;
      4'b00_01: blk = 3'd1;
      4'b01_00: blk = 3'd2;
      4'b01_01: blk = 3'd3;
      4'b10_01: blk = {1'b1, bank_q};
      default:  rom_hit = 1'b0;
    endcase
  end

  assign unmapped = win_hit && !rom_hit && slot != 2'd3;

  assign trap_cs    = mem_cyc && trap;
  assign slot_cs    = win_hit ? 4'(1 << slot) : 4'd0;
  assign rom_cs     = win_hit && rom_hit;
  assign rom_addr   = {blk, addr[13:0]};
  assign dram_cs    = mem_cyc && ((region == 2'd0 && !legacy) || (win_hit && slot == 2'd3));
  assign dram_addr  = legacy ? {map_q[page], addr[13:0]} : addr[21:0];
  assign flash_cs   = mem_cyc && region == 2'd3;
  assign flash_addr = addr[21:0];
  assign ext_cs     = mem_cyc ? {region == 2'd2, region == 2'd1} : 2'b00;

  always_comb begin
    rd_drive = 1'b1;
    rd_data  = 8'hFF;
    if (io_rd && slot_port)       rd_data = slot_q;
    else if (io_rd && map_port)   rd_data = map_q[port[1:0]];
    else if (!(mem_rd && unmapped)) rd_drive = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= 8'h00;
      bank_q <= 2'd0;
      for (int i = 0; i < 4; i++) map_q[i] <= 8'(3 - i);
    end else begin
      if (io_wr && slot_port) slot_q <= wdata;
      if (io_wr && map_port)  map_q[port[1:0]] <= wdata;
      if (mem_wr && legacy && addr[15:0] == BANK_ADDR && slot == 2'd2)
        bank_q <= wdata[1:0];
    end
  end

endmodule

// File: rtl/slot_map_decoder_chk.sv
module slot_map_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        io_rd,
  input logic        trap_cs,
  input logic        rom_cs,
  input logic        dram_cs,
  input logic        flash_cs,
  input logic [21:0] flash_addr,
  input logic [1:0]  ext_cs,
  input logic [3:0]  slot_cs,
  input logic        rd_drive,
  input logic [7:0]  rd_data
);

  // R9
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_cs, rom_cs, dram_cs, flash_cs, ext_cs}));

  // R2
  trap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && addr[23:2] == 22'd0 |-> trap_cs && slot_cs == 4'd0);

  // R1
  ext_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && addr[23:22] == 2'b01 |-> ext_cs == 2'b01);

  // R1
  flash_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && addr[23:22] == 2'b11 |-> flash_cs && flash_addr == addr[21:0]);

  // R7
  float_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive && !io_rd |-> rd_data == 8'hFF);

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd || mem_wr) |-> !trap_cs && !rom_cs && !dram_cs && !flash_cs
                            && ext_cs == 2'b00 && slot_cs == 4'd0);

endmodule

bind slot_map_decoder slot_map_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .io_rd(io_rd), .trap_cs(trap_cs), .rom_cs(rom_cs), .dram_cs(dram_cs),
  .flash_cs(flash_cs), .flash_addr(flash_addr), .ext_cs(ext_cs),
  .slot_cs(slot_cs), .rd_drive(rd_drive), .rd_data(rd_data)
);

// File: tb/slot_map_decoder_tb.sv
module slot_map_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
  logic        trap_cs, rom_cs, dram_cs, flash_cs, rd_drive;
  logic [16:0] rom_addr;
  logic [21:0] dram_addr, flash_addr;
  logic [1:0]  ext_cs, page;
  logic [3:0]  slot_cs;
  logic [7:0]  rd_data;

  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  slot_map_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .trap_cs(trap_cs), .rom_cs(rom_cs), .rom_addr(rom_addr),
    .dram_cs(dram_cs), .dram_addr(dram_addr), .flash_cs(flash_cs),
    .flash_addr(flash_addr), .ext_cs(ext_cs), .slot_cs(slot_cs),
    .page(page), .rd_drive(rd_drive), .rd_data(rd_data)
  );

  // {addr, cs = {trap,rom,flash,dram,ext1,ext0}, expected device address}
  localparam int NV = 14;
  localparam logic [51:0] VEC [NV] = '{
    {24'h000000, 6'b100000, 22'h000000},
    {24'h000003, 6'b100000, 22'h000000},
    {24'h000004, 6'b010000, 22'h000004},
    {24'h005678, 6'b010000, 22'h005678},
    {24'h008000, 6'b000000, 22'h000000},
    {24'h00FFFF, 6'b000000, 22'h000000},
    {24'h010000, 6'b000100, 22'h010000},
    {24'h3FFFFF, 6'b000100, 22'h3FFFFF},
    {24'h400000, 6'b000001, 22'h000000},
    {24'h7FFFFF, 6'b000001, 22'h000000},
    {24'h800000, 6'b000010, 22'h000000},
    {24'hBFFFFF, 6'b000010, 22'h000000},
    {24'hC00000, 6'b001000, 22'h000000},
    {24'hFFFFFF, 6'b001000, 22'h3FFFFF}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] cs_now();
    return {trap_cs, rom_cs, flash_cs, dram_cs, ext_cs};
  endfunction

  task automatic idle();
    mem_rd = 1'b0; mem_wr = 1'b0; io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic io_write(logic [7:0] p, logic [7:0] d);
    @(negedge clk); idle(); addr = {16'h0, p}; wdata = d; io_wr = 1'b1;
    @(negedge clk); idle();
  endtask

  task automatic mem_write(logic [23:0] a, logic [7:0] d);
    @(negedge clk); idle(); addr = a; wdata = d; mem_wr = 1'b1;
    @(negedge clk); idle();
  endtask

  task automatic io_read(logic [7:0] p, logic [7:0] exp, string req);
    @(negedge clk); idle(); addr = {16'h0, p}; io_rd = 1'b1; #1;
    check(req, {23'd0, rd_drive, rd_data}, {23'd0, 1'b1, exp});
  endtask

  task automatic mem_read(logic [23:0] a);
    @(negedge clk); idle(); addr = a; mem_rd = 1'b1; #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 / R4 / R8: reset values read back through I/O
    io_read(8'hA8, 8'h00, "R3_reset");
    io_read(8'hFC, 8'h03, "R4_reset_p0");
    io_read(8'hFD, 8'h02, "R4_reset_p1");
    io_read(8'hFE, 8'h01, "R4_reset_p2");
    io_read(8'hFF, 8'h00, "R8_reset_p3");

    // R1 R2 R5 R7: region and default-slot table
    for (int i = 0; i < NV; i++) begin
      mem_read(VEC[i][51:28]);
      check("R1_table_cs", {26'd0, cs_now()}, {26'd0, VEC[i][27:22]});
      if (VEC[i][24]) check("R1_dram_addr", {10'd0, dram_addr}, {10'd0, VEC[i][21:0]});
      if (VEC[i][25]) check("R1_flash_addr", {10'd0, flash_addr}, {10'd0, VEC[i][21:0]});
      if (VEC[i][26]) check("R5_rom_addr", {15'd0, rom_addr}, {15'd0, VEC[i][21:0]});
    end

    // R10: no strobe, no select
    @(negedge clk); idle(); addr = 24'h010000; #1;
    check("R10_idle", {26'd0, cs_now(), slot_cs}, 32'd0);

    // R3 R8: pages 0..3 on slots 0..3
    io_write(8'hA8, 8'hE4);
    io_read(8'hA8, 8'hE4, "R8_slot_rb");
    mem_read(24'h000010);
    check("R3_slot0", {28'd0, slot_cs}, 32'h1);
    check("R5_bios", {15'd0, rom_addr}, 32'h00010);
    mem_read(24'h004010);
    check("R3_slot1", {28'd0, slot_cs}, 32'h2);
    check("R5_bdos", {15'd0, rom_cs, rom_addr}, {15'd0, 1'b1, 17'h0C010});
    mem_read(24'h008000);
    check("R3_page2", {30'd0, page}, 32'd2);
    check("R7_unmapped", {22'd0, cs_now(), rd_drive, rd_data}, {22'd0, 6'd0, 1'b1, 8'hFF});
    mem_read(24'h00C123);
    check("R4_map_p3", {9'd0, dram_cs, dram_addr}, {9'd0, 1'b1, 22'h000123});
    io_write(8'hFF, 8'h55);
    io_read(8'hFF, 8'h55, "R8_map_rb");
    mem_read(24'h00C123);
    check("R4_map_write", {9'd0, dram_cs, dram_addr}, {9'd0, 1'b1, 22'h154123});

    // R4: page 1 via slot 3 uses reset entry 2
    io_write(8'hA8, 8'h0C);
    mem_read(24'h004001);
    check("R4_map_p1", {9'd0, dram_cs, dram_addr}, {9'd0, 1'b1, 22'h008001});

    // R2: trap wins over slot 3
    io_write(8'hA8, 8'h03);
    mem_read(24'h000001);
    check("R2_trap_slot3", {26'd0, cs_now()}, {26'd0, 6'b100000});

    // R5: extended BIOS on slot 1 page 0
    io_write(8'hA8, 8'h01);
    mem_read(24'h000100);
    check("R5_xbios", {15'd0, rom_cs, rom_addr}, {15'd0, 1'b1, 17'h08100});

    // R6: DOS bank register
    io_write(8'hA8, 8'h08);
    mem_read(24'h004000);
    check("R6_bank0", {15'd0, rom_cs, rom_addr}, {15'd0, 1'b1, 17'h10000});
    mem_write(24'h004104, 8'h02);
    mem_read(24'h004000);
    check("R6_bank2", {15'd0, rom_addr}, 32'h18000);
    io_write(8'hA8, 8'h00);
    mem_write(24'h004104, 8'h03);
    io_write(8'hA8, 8'h08);
    mem_read(24'h004000);
    check("R6_ignored", {15'd0, rom_addr}, 32'h18000);

    // R9: one select on a DRAM access
    mem_read(24'h123456);
    check("R9_single", {26'd0, cs_now()}, {26'd0, 6'b000100});

    @(negedge clk); idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule